// File: doc/BRIEF.md
# Encoder Position Capture and Event Flags

This block sits beside a quadrature decoder. It watches the decoder's live position count and its one-cycle event pulses. It keeps two snapshot registers. The hold snapshot is taken on request, and the request can come from software or from one of four timer-match inputs, each of which has its own enable. The index snapshot is taken on each index rising edge.

Four sticky event flags record index, compare match, counter wrap and direction change. Software clears each flag by writing 1 to it. The live counting direction is also reported. The flags are masked by per-flag enables and ORed into a single interrupt line.

Software reaches the block through a small register port with a write strobe and a read strobe, selected by a 2-bit register select. The registers are:

| Select | Register |
|--------|----------|
| 0 | control |
| 1 | status |
| 2 | hold snapshot |
| 3 | index snapshot |

Read data is registered.

Top module: `qenc_capture_flags`

## Requirements
- R1: After reset the control word, status flags, hold snapshot and index snapshot are all 0 and `irq_o` is 0.
- R2: Control word layout (select 0):
  - bits [3:0] are the interrupt enables, in the flag order given in R6;
  - bits [7:4] are the hold enables for timers 0..3;
  - bit 8 enables the index snapshot;
  - bit 9 is the hold trigger.

  Writing 1 to bit 9 sets the trigger. The hold snapshot then loads `count_i` at the clock edge that follows. Bit 9 reads as 1 while the trigger is set.
- R3: A pulse on `tmr_match_i[k]` sets the hold trigger only when control bit 4+k is 1. A match from a disabled timer leaves the hold snapshot and the trigger unchanged.
- R4: The trigger clears itself one cycle after the capture. Requests that arrive together produce a single capture. So do requests that arrive while the trigger is set.
- R5: On `idx_rise_i` with control bit 8 set, the index snapshot loads `count_i`. With bit 8 clear, the index snapshot is unchanged.
- R6: A pulse sets the matching sticky flag in status bits [3:0], whether or not any enable is set. The pulses and flags are `idx_rise_i` (bit 0), `cmp_hit_i` (bit 1), `wrap_i` (bit 2) and `dir_chg_i` (bit 3).
- R7: A write to status (select 1) clears each flag whose data bit is 1. Flags whose data bit is 0 are left as they are.
- R8: If a flag's event and its write-1 clear happen in the same cycle, the flag ends up set.
- R9: Status bit 8 reports `dir_up_i`, where 1 means counting up and 0 means counting down.
- R10: `irq_o` is 1 exactly when some flag is set and its enable bit in control [3:0] is set.
- R11: Software can write the hold snapshot (select 2) and the index snapshot (select 3) directly, and read them back.
- R12: `rdata_o` takes the selected register's value at the clock edge where `rd_i` is 1. It holds that value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_i | input | CNT_W | Live position count from the decoder |
| dir_up_i | input | 1 | Current direction, 1 = up |
| idx_rise_i | input | 1 | Index rising-edge pulse |
| cmp_hit_i | input | 1 | Compare-match pulse |
| wrap_i | input | 1 | Overflow/underflow pulse |
| dir_chg_i | input | 1 | Direction-change pulse |
| tmr_match_i | input | 4 | Timer-match pulses, timers 0..3 |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Registered read data |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench targets the cases most likely to be wrong:
- A software write and an enabled timer match are issued in the same cycle, and a further match arrives while the trigger is still set. A design that captured on the level of the trigger, or on each request, would overwrite the hold snapshot with a later count.
- An index event lands in the same cycle as a write-1 clear of that flag. A design that gave the clear priority would lose the event.
- A match arrives from a disabled timer, and an index edge arrives with the index snapshot disabled. A design that ignored the enables would corrupt the snapshots.
- The interrupt line is checked against flags with and without enables. This catches a line wired to the raw flags.

// File: rtl/qcf_pkg.sv
package qcf_pkg;
    localparam int NUM_TMR  = 4;
    localparam int NUM_FLAG = 4;
    localparam int DIR_BIT  = 8;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_STAT  = 2'd1,
        SEL_HOLD  = 2'd2,
        SEL_LATCH = 2'd3
    } qcf_sel_e;

    // packed MSB first: hold_go is bit 9, irq_en is bits 3:0
    typedef struct packed {
        logic                hold_go;
        logic                latch_en;
        logic [NUM_TMR-1:0]  tmr_en;
        logic [NUM_FLAG-1:0] irq_en;
    } qcf_ctrl_t;

    localparam int CTRL_W = $bits(qcf_ctrl_t);

    function automatic logic [31:0] stat_word(input logic [NUM_FLAG-1:0] flags, input logic dir);
        logic [31:0] w;
        w = '0;
        w[NUM_FLAG-1:0] = flags;
        w[DIR_BIT] = dir;
        return w;
    endfunction
endpackage

// File: rtl/qcf_hold_unit.sv
module qcf_hold_unit #(
    parameter int CNT_W = 32,
    parameter int N_TMR = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_go,
    input  logic [N_TMR-1:0] tmr_match,
    input  logic [N_TMR-1:0] tmr_en,
    input  logic             sw_wr,
    input  logic [CNT_W-1:0] sw_data,
    input  logic [CNT_W-1:0] count,
    output logic             busy_o,
    output logic             prev_o,
    output logic [CNT_W-1:0] hold_o
);
    logic req;
    assign req = sw_go | (|(tmr_match & tmr_en));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            prev_o <= 1'b0;
            hold_o <= '0;
        end else begin
            prev_o <= busy_o;
            if (busy_o && prev_o)
                busy_o <= 1'b0;
            else if (req && !busy_o)
                busy_o <= 1'b1;
            if (busy_o && !prev_o)
                hold_o <= count;
            else if (sw_wr)
                hold_o <= sw_data;
        end
    end
endmodule

// File: rtl/qcf_flag_bank.sv
module qcf_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags_o[i] <= 1'b0;
            else if (evt[i])
                flags_o[i] <= 1'b1;
            else if (clr[i])
                flags_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/qcf_index_latch.sv
module qcf_index_latch #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             idx,
    input  logic             sw_wr,
    input  logic [CNT_W-1:0] sw_data,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] latch_o
);
    always_ff @(posedge clk) begin
        if (rst)
            latch_o <= '0;
        else if (en && idx)
            latch_o <= count;
        else if (sw_wr)
            latch_o <= sw_data;
    end
endmodule

// File: rtl/qenc_capture_flags.sv
module qenc_capture_flags
    import qcf_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count_i,
    input  logic             dir_up_i,
    input  logic             idx_rise_i,
    input  logic             cmp_hit_i,
    input  logic             wrap_i,
    input  logic             dir_chg_i,
    input  logic [3:0]       tmr_match_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [1:0]       addr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rdata_o,
    output logic             irq_o
);
    qcf_ctrl_t             ctrl_q;
    qcf_ctrl_t             wr_ctrl;
    logic [NUM_FLAG-1:0]   evt;
    logic [NUM_FLAG-1:0]   flag_clr;
    logic [NUM_FLAG-1:0]   flag_q;
    logic                  hold_busy;
    logic                  hold_prev;
    logic [CNT_W-1:0]      hold_q;
    logic [CNT_W-1:0]      latch_q;
    logic                  wr_ctrl_hit;
    logic [CNT_W-1:0]      rd_mux;
    logic [31:0]           stat_w;

    assign evt         = {dir_chg_i, wrap_i, cmp_hit_i, idx_rise_i};
    assign wr_ctrl_hit = wr_i && (addr_i == SEL_CTRL);
    assign wr_ctrl     = qcf_ctrl_t'(wdata_i[CTRL_W-1:0]);
    assign flag_clr    = (wr_i && addr_i == SEL_STAT) ? wdata_i[NUM_FLAG-1:0] : '0;

    // enables; the hold_go field of ctrl_q is unused, the live trigger comes from the hold unit
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl_hit) begin
            ctrl_q         <= wr_ctrl;
            ctrl_q.hold_go <= 1'b0;
        end
    end

    qcf_hold_unit #(.CNT_W(CNT_W), .N_TMR(NUM_TMR)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .sw_go     (wr_ctrl_hit && wr_ctrl.hold_go),
        .tmr_match (tmr_match_i),
        .tmr_en    (ctrl_q.tmr_en),
        .sw_wr     (wr_i && addr_i == SEL_HOLD),
        .sw_data   (wdata_i),
        .count     (count_i),
        .busy_o    (hold_busy),
        .prev_o    (hold_prev),
        .hold_o    (hold_q)
    );

    qcf_flag_bank #(.N(NUM_FLAG)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .clr     (flag_clr),
        .flags_o (flag_q)
    );

    qcf_index_latch #(.CNT_W(CNT_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_q.latch_en),
        .idx     (idx_rise_i),
        .sw_wr   (wr_i && addr_i == SEL_LATCH),
        .sw_data (wdata_i),
        .count   (count_i),
        .latch_o (latch_q)
    );

    assign stat_w = stat_word(flag_q, dir_up_i);

    always_comb begin
        rd_mux = '0;
        case (qcf_sel_e'(addr_i))
            SEL_CTRL: begin
                rd_mux[CTRL_W-1:0]  = ctrl_q;
                rd_mux[CTRL_W-1]    = hold_busy;
            end
            SEL_STAT:  rd_mux = CNT_W'(stat_w);
            SEL_HOLD:  rd_mux = hold_q;
            default:   rd_mux = latch_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_o <= '0;
        else if (rd_i)
            rdata_o <= rd_mux;
    end

    assign irq_o = |(flag_q & ctrl_q.irq_en);
endmodule

// File: rtl/qcf_capture_flags_chk.sv
module qcf_capture_flags_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count_i,
    input logic             idx_rise_i,
    input logic             latch_en,
    input logic [3:0]       evt,
    input logic [3:0]       flag_q,
    input logic [3:0]       irq_en,
    input logic             hold_busy,
    input logic             hold_prev,
    input logic [CNT_W-1:0] hold_q,
    input logic [CNT_W-1:0] latch_q,
    input logic             wr_i,
    input logic [1:0]       addr_i,
    input logic [CNT_W-1:0] wdata_i,
    input logic             irq_o
);
    assert_hold_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (hold_busy && !hold_prev) |=> (hold_q == $past(count_i)));

    assert_hold_selfclear_R4: assert property (@(posedge clk) disable iff (rst)
        (hold_busy && hold_prev) |=> !hold_busy);

    assert_index_latch_R5: assert property (@(posedge clk) disable iff (rst)
        (idx_rise_i && latch_en) |=> (latch_q == $past(count_i)));

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
        (evt != 4'd0) |=> ((flag_q & $past(evt)) == $past(evt)));

    assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i == 2'd1 && evt == 4'd0) |=> (flag_q == ($past(flag_q) & ~$past(wdata_i[3:0]))));

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        ((flag_q & irq_en) == 4'd0) |-> !irq_o);
endmodule

bind qenc_capture_flags qcf_capture_flags_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .count_i    (count_i),
    .idx_rise_i (idx_rise_i),
    .latch_en   (ctrl_q.latch_en),
    .evt        (evt),
    .flag_q     (flag_q),
    .irq_en     (ctrl_q.irq_en),
    .hold_busy  (hold_busy),
    .hold_prev  (hold_prev),
    .hold_q     (hold_q),
    .latch_q    (latch_q),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .irq_o      (irq_o)
);

// File: tb/qenc_capture_flags_test.sv
module qenc_capture_flags_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        string       req;
        logic [1:0]  sel;
        logic [31:0] val;
    } exp_t;

    logic        clk = 0;
    logic        rst = 1;
    logic [31:0] count_i = 32'h100;
    logic        dir_up_i = 0;
    logic        idx_rise_i = 0, cmp_hit_i = 0, wrap_i = 0, dir_chg_i = 0;
    logic [3:0]  tmr_match_i = 0;
    logic        wr_i = 0, rd_i = 0;
    logic [1:0]  addr_i = 0;
    logic [31:0] wdata_i = 0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int   checks = 0;
    int   errors = 0;
    logic rd_q = 0;
    bit   done = 0;
    exp_t sb[$];

    qenc_capture_flags uut (
        .clk(clk), .rst(rst), .count_i(count_i), .dir_up_i(dir_up_i),
        .idx_rise_i(idx_rise_i), .cmp_hit_i(cmp_hit_i), .wrap_i(wrap_i),
        .dir_chg_i(dir_chg_i), .tmr_match_i(tmr_match_i), .wr_i(wr_i),
        .rd_i(rd_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) rd_q <= rd_i;

    // monitor: registered read data is valid at the negedge after the sampling edge
    always @(negedge clk) begin
        if (rd_q) begin
            exp_t e;
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL %s: read data %h with empty scoreboard, expected none", "R12", rdata_o);
            end else begin
                e = sb.pop_front();
                if (rdata_o !== e.val) begin
                    errors++;
                    $display("FAIL %s: sel %0d actual %h expected %h", e.req, e.sel, rdata_o, e.val);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [1:0] sel, input logic [31:0] d);
        wr_i = 1; addr_i = sel; wdata_i = d;
        @(negedge clk);
        wr_i = 0;
    endtask

    task automatic bus_rd(input logic [1:0] sel, input logic [31:0] exp_v, input string req);
        exp_t e;
        e.req = req; e.sel = sel; e.val = exp_v;
        sb.push_back(e);
        rd_i = 1; addr_i = sel;
        @(negedge clk);
        rd_i = 0;
    endtask

    task automatic pulse(input logic [3:0] ev, input logic [3:0] tm);
        {dir_chg_i, wrap_i, cmp_hit_i, idx_rise_i} = ev;
        tmr_match_i = tm;
        @(negedge clk);
        {dir_chg_i, wrap_i, cmp_hit_i, idx_rise_i} = 4'd0;
        tmr_match_i = 4'd0;
    endtask

    task automatic chk_irq(input logic exp_v, input string req);
        checks++;
        if (irq_o !== exp_v) begin
            errors++;
            $display("FAIL %s: irq actual %b expected %b", req, irq_o, exp_v);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk_irq(1'b0, "R1");
        bus_rd(2'd0, 32'h0, "R1");
        bus_rd(2'd1, 32'h0, "R1");
        bus_rd(2'd2, 32'h0, "R1");
        bus_rd(2'd3, 32'h0, "R1");
        // R9 direction bit
        dir_up_i = 1;
        bus_rd(2'd1, 32'h100, "R9");

        // R2 software hold: trigger visible, capture, then self-clear (R4)
        count_i = 32'h1234;
        bus_wr(2'd0, 32'h200);
        bus_rd(2'd0, 32'h200, "R2");
        bus_rd(2'd2, 32'h1234, "R2");
        bus_rd(2'd0, 32'h0, "R4");
        count_i = 32'h9999;
        bus_rd(2'd2, 32'h1234, "R12");

        // R3 disabled timer ignored
        count_i = 32'h5555;
        pulse(4'd0, 4'b0010);
        idle(3);
        bus_rd(2'd0, 32'h0, "R3");
        bus_rd(2'd2, 32'h1234, "R3");

        // R3 enabled timer 1 triggers a capture
        bus_wr(2'd0, 32'h020);
        count_i = 32'h7777;
        pulse(4'd0, 4'b0010);
        idle(3);
        bus_rd(2'd2, 32'h7777, "R3");

        // R4 simultaneous requests, plus a request while busy: one capture only
        count_i = 32'hAAAA;
        wr_i = 1; addr_i = 2'd0; wdata_i = 32'h220; tmr_match_i = 4'b0010;
        @(negedge clk);
        wr_i = 0; tmr_match_i = 0;
        @(negedge clk);
        count_i = 32'hBBBB;
        pulse(4'd0, 4'b0010);
        idle(3);
        bus_rd(2'd2, 32'hAAAA, "R4");
        bus_rd(2'd0, 32'h020, "R4");

        // R11 direct writes
        bus_wr(2'd2, 32'hCAFE);
        bus_rd(2'd2, 32'hCAFE, "R11");
        bus_wr(2'd3, 32'hF00D);
        bus_rd(2'd3, 32'hF00D, "R11");

        // R5 index with latch disabled: latch unchanged, flag still set (R6)
        count_i = 32'h4242;
        pulse(4'b0001, 4'd0);
        bus_rd(2'd3, 32'hF00D, "R5");
        bus_rd(2'd1, 32'h101, "R6");

        // R5 index with latch enabled
        bus_wr(2'd0, 32'h100);
        count_i = 32'h4343;
        pulse(4'b0001, 4'd0);
        bus_rd(2'd3, 32'h4343, "R5");

        // R6 sticky flags
        pulse(4'b1110, 4'd0);
        idle(4);
        bus_rd(2'd1, 32'h10F, "R6");

        // R7 write-1 clears only selected flags
        bus_wr(2'd1, 32'h002);
        bus_rd(2'd1, 32'h10D, "R7");

        // R8 set wins against same-cycle clear
        wr_i = 1; addr_i = 2'd1; wdata_i = 32'h001; idx_rise_i = 1;
        @(negedge clk);
        wr_i = 0; idx_rise_i = 0;
        bus_rd(2'd1, 32'h10D, "R8");

        // R10 interrupt masking
        chk_irq(1'b0, "R10");
        bus_wr(2'd0, 32'h102);
        chk_irq(1'b0, "R10");
        bus_wr(2'd0, 32'h104);
        chk_irq(1'b1, "R10");
        bus_wr(2'd1, 32'h00F);
        chk_irq(1'b0, "R10");
        bus_rd(2'd1, 32'h100, "R7");

        // R9 direction down
        dir_up_i = 0;
        bus_rd(2'd1, 32'h000, "R9");

        idle(3);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R12: %0d reads unanswered, expected 0", sb.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule